// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block sits beside a two-port 1K x 8 memory and gives each port an active-low interrupt output. It watches the chip enable, write strobe, output enable, busy input and address of both ports. It raises or clears the interrupts only as a side effect of ordinary accesses to the two highest memory words. The memory stores the written data. This block only keeps the two flags.

The left port signals the right port by writing the highest word. The right port acknowledges by reading that word. In the other direction, the right port signals the left port by writing the next-highest word. The left port acknowledges by reading that word. A port whose busy input is asserted has no effect on either flag. Both flags are registered, so an access sampled at a rising clock edge is visible on the outputs after that edge.

Top module: `mbox_irq`

## Requirements
- R1: After reset both `l_int_no` and `r_int_no` are high (inactive).
- R2: A left write to address 0x3FF drives `r_int_no` low after the sampling edge. A write needs `l_ce_ni`=0, `l_wr_ni`=0 and `l_busy_ni`=1.
- R3: A right read of address 0x3FF drives `r_int_no` high after the sampling edge. A read needs `r_ce_ni`=0, `r_wr_ni`=1, `r_oe_ni`=0 and `r_busy_ni`=1.
- R4: A right write to address 0x3FE drives `l_int_no` low after the sampling edge. The write conditions are the same as in R2, on the right port.
- R5: A left read of address 0x3FE drives `l_int_no` high after the sampling edge. The read conditions are the same as in R3, on the left port.
- R6: A read with output enable high (`*_oe_ni`=1) does not clear a flag.
- R7: Accesses to any address other than 0x3FE and 0x3FF leave both flags unchanged. Cycles with chip enable high also leave both flags unchanged.
- R8: When a port's busy input is low (asserted), that port's writes do not set a flag and its reads do not clear one.
- R9: When a set and a clear of the same flag occur in the same cycle, the flag ends up set (output low).
- R10: These cross accesses change neither flag: a port writing the word that its peer writes to it, or a port reading the word that it writes to its peer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_ce_ni | input | 1 | Left chip enable, active low |
| l_wr_ni | input | 1 | Left read/write: 0 = write, 1 = read |
| l_oe_ni | input | 1 | Left output enable, active low |
| l_busy_ni | input | 1 | Left busy, active low |
| l_addr_i | input | ADDR_W | Left address |
| r_ce_ni | input | 1 | Right chip enable, active low |
| r_wr_ni | input | 1 | Right read/write: 0 = write, 1 = read |
| r_oe_ni | input | 1 | Right output enable, active low |
| r_busy_ni | input | 1 | Right busy, active low |
| r_addr_i | input | ADDR_W | Right address |
| l_int_no | output | 1 | Interrupt to the left port, active low |
| r_int_no | output | 1 | Interrupt to the right port, active low |

## Verification
Each access is sampled at one rising edge. Its effect on both interrupt outputs is due right after that edge, with exactly one cycle of latency and no combinational path. The driver applies each access at a falling edge. After the next rising edge it pushes the expected pair of flag values. The monitor compares them at the following falling edge, one item per cycle. Because of this, every check looks at the outputs exactly one edge after its stimulus.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;
  typedef enum logic {PORT_L = 1'b0, PORT_R = 1'b1} port_e;

  typedef struct packed {
    logic send;  // write hit on the word that interrupts the peer
    logic ack;   // read hit on the word that interrupts this port
  } mbox_evt_t;
endpackage

// File: rtl/mbox_port_dec.sv
module mbox_port_dec
  import mbox_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter logic [ADDR_W-1:0] SEND_ADDR = '1,
  parameter logic [ADDR_W-1:0] ACK_ADDR = '0
) (
  input  logic              ce_ni,
  input  logic              wr_ni,
  input  logic              oe_ni,
  input  logic              busy_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output mbox_evt_t         evt_o
);
  logic act, is_wr, is_rd;

  assign act   = !ce_ni && busy_ni;
  assign is_wr = act && !wr_ni;
  assign is_rd = act && wr_ni && !oe_ni;

  always_comb begin
    evt_o.send = is_wr && (addr_i == SEND_ADDR);
    evt_o.ack  = is_rd && (addr_i == ACK_ADDR);
  end
endmodule

// File: rtl/mbox_flag.sv
module mbox_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic int_no
);
  logic pend_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (set_i) pend_q <= 1'b1;
    else if (clr_i) pend_q <= 1'b0;
  end

  assign int_no = !pend_q;
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq
  import mbox_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_ce_ni,
  input  logic              l_wr_ni,
  input  logic              l_oe_ni,
  input  logic              l_busy_ni,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic              r_ce_ni,
  input  logic              r_wr_ni,
  input  logic              r_oe_ni,
  input  logic              r_busy_ni,
  input  logic [ADDR_W-1:0] r_addr_i,
  output logic              l_int_no,
  output logic              r_int_no
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;
  localparam logic [ADDR_W-1:0] NXT_ADDR = TOP_ADDR - 1'b1;
  localparam int unsigned NPORT = 2;

  logic [NPORT-1:0]              ce_n, wr_n, oe_n, busy_n, int_n;
  logic [NPORT-1:0][ADDR_W-1:0]  addr;
  mbox_evt_t [NPORT-1:0]         evt;

  assign ce_n   = {r_ce_ni,   l_ce_ni};
  assign wr_n   = {r_wr_ni,   l_wr_ni};
  assign oe_n   = {r_oe_ni,   l_oe_ni};
  assign busy_n = {r_busy_ni, l_busy_ni};
  assign addr   = {r_addr_i,  l_addr_i};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    // left sends on the top word, right sends on the one below
    localparam logic [ADDR_W-1:0] SEND = (p == int'(PORT_L)) ? TOP_ADDR : NXT_ADDR;
    localparam logic [ADDR_W-1:0] ACK  = (p == int'(PORT_L)) ? NXT_ADDR : TOP_ADDR;

    mbox_port_dec #(
      .ADDR_W(ADDR_W), .SEND_ADDR(SEND), .ACK_ADDR(ACK)
    ) u_dec (
      .ce_ni(ce_n[p]), .wr_ni(wr_n[p]), .oe_ni(oe_n[p]),
      .busy_ni(busy_n[p]), .addr_i(addr[p]), .evt_o(evt[p])
    );

    mbox_flag u_flag (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .set_i(evt[NPORT-1-p].send), .clr_i(evt[p].ack),
      .int_no(int_n[p])
    );
  end

  assign l_int_no = int_n[PORT_L];
  assign r_int_no = int_n[PORT_R];
endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk #(
  parameter int unsigned ADDR_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              l_ce_ni,
  input logic              l_wr_ni,
  input logic              l_oe_ni,
  input logic              l_busy_ni,
  input logic [ADDR_W-1:0] l_addr_i,
  input logic              r_ce_ni,
  input logic              r_wr_ni,
  input logic              r_oe_ni,
  input logic              r_busy_ni,
  input logic [ADDR_W-1:0] r_addr_i,
  input logic              l_int_no,
  input logic              r_int_no
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;
  localparam logic [ADDR_W-1:0] NXT_ADDR = TOP_ADDR - 1'b1;

  // R2 / R9
  l_send_sets_r_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_ce_ni && !l_wr_ni && l_busy_ni && l_addr_i == TOP_ADDR) |=> !r_int_no);
  // R4 / R9
  r_send_sets_l_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!r_ce_ni && !r_wr_ni && r_busy_ni && r_addr_i == NXT_ADDR) |=> !l_int_no);
  // R3
  r_ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!r_ce_ni && r_wr_ni && !r_oe_ni && r_busy_ni && r_addr_i == TOP_ADDR &&
     !(!l_ce_ni && !l_wr_ni && l_busy_ni && l_addr_i == TOP_ADDR)) |=> r_int_no);
  // R5
  l_ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_ce_ni && l_wr_ni && !l_oe_ni && l_busy_ni && l_addr_i == NXT_ADDR &&
     !(!r_ce_ni && !r_wr_ni && r_busy_ni && r_addr_i == NXT_ADDR)) |=> l_int_no);
  // R7
  idle_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_ce_ni && r_ce_ni) |=> ($stable(l_int_no) && $stable(r_int_no)));
  // R8
  busy_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_busy_ni && !r_busy_ni) |=> ($stable(l_int_no) && $stable(r_int_no)));
endmodule

bind mbox_irq mbox_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .l_ce_ni(l_ce_ni), .l_wr_ni(l_wr_ni), .l_oe_ni(l_oe_ni),
  .l_busy_ni(l_busy_ni), .l_addr_i(l_addr_i),
  .r_ce_ni(r_ce_ni), .r_wr_ni(r_wr_ni), .r_oe_ni(r_oe_ni),
  .r_busy_ni(r_busy_ni), .r_addr_i(r_addr_i),
  .l_int_no(l_int_no), .r_int_no(r_int_no)
);

// File: tb/mbox_irq_bench.sv
module mbox_irq_bench;
  localparam int unsigned AW = 10;
  localparam logic [AW-1:0] TOP = 10'h3FF;
  localparam logic [AW-1:0] NXT = 10'h3FE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_ce_n = 1'b1, l_wr_n = 1'b1, l_oe_n = 1'b1, l_busy_n = 1'b1;
  logic r_ce_n = 1'b1, r_wr_n = 1'b1, r_oe_n = 1'b1, r_busy_n = 1'b1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_int_n, r_int_n;

  always #4 clk = ~clk;  // 125 MHz

  mbox_irq #(.ADDR_W(AW)) u_mbox_irq (
    .clk_i(clk), .rst_ni(rst_n),
    .l_ce_ni(l_ce_n), .l_wr_ni(l_wr_n), .l_oe_ni(l_oe_n),
    .l_busy_ni(l_busy_n), .l_addr_i(l_addr),
    .r_ce_ni(r_ce_n), .r_wr_ni(r_wr_n), .r_oe_ni(r_oe_n),
    .r_busy_ni(r_busy_n), .r_addr_i(r_addr),
    .l_int_no(l_int_n), .r_int_no(r_int_n)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [1:0] q_exp[$];
  string q_tag[$];
  logic ml_n = 1'b1, mr_n = 1'b1;  // model flags, active low

  // monitor
  always @(negedge clk) begin
    if (q_exp.size() > 0) begin
      logic [1:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      n_chk++;
      if ({l_int_n, r_int_n} !== e) begin
        n_fail++;
        $display("FAIL %s: {l,r}=%b expected %b", t, {l_int_n, r_int_n}, e);
      end
    end
  end

  task automatic cyc(input logic lce, lwr, loe, input logic [AW-1:0] la, input logic lb,
                     input logic rce, rwr, roe, input logic [AW-1:0] ra, input logic rb,
                     input string tag);
    logic set_r, clr_r, set_l, clr_l;
    @(negedge clk);
    l_ce_n = lce; l_wr_n = lwr; l_oe_n = loe; l_addr = la; l_busy_n = lb;
    r_ce_n = rce; r_wr_n = rwr; r_oe_n = roe; r_addr = ra; r_busy_n = rb;
    set_r = !lce && !lwr && lb && la == TOP;
    clr_r = !rce && rwr && !roe && rb && ra == TOP;
    set_l = !rce && !rwr && rb && ra == NXT;
    clr_l = !lce && lwr && !loe && lb && la == NXT;
    @(posedge clk);
    if (set_r) mr_n = 1'b0; else if (clr_r) mr_n = 1'b1;
    if (set_l) ml_n = 1'b0; else if (clr_l) ml_n = 1'b1;
    q_exp.push_back({ml_n, mr_n});
    q_tag.push_back(tag);
  endtask

  // one-sided helpers; the other port idles
  task automatic lacc(input logic ce, wr, oe, input logic [AW-1:0] a, input logic b, input string tag);
    cyc(ce, wr, oe, a, b, 1'b1, 1'b1, 1'b1, '0, 1'b1, tag);
  endtask
  task automatic racc(input logic ce, wr, oe, input logic [AW-1:0] a, input logic b, input string tag);
    cyc(1'b1, 1'b1, 1'b1, '0, 1'b1, ce, wr, oe, a, b, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    lacc(1, 1, 1, '0, 1, "R1 reset idle");
    lacc(0, 0, 1, TOP, 1, "R2 left write 3FF sets right");
    racc(0, 1, 1, TOP, 1, "R6 right read oe high keeps");
    racc(1, 1, 0, TOP, 1, "R7 right ce high keeps");
    racc(0, 0, 1, TOP, 1, "R10 right write 3FF no effect");
    lacc(0, 1, 0, TOP, 1, "R10 left read 3FF no effect");
    racc(0, 1, 0, TOP, 1, "R3 right read 3FF clears");
    racc(0, 0, 1, NXT, 1, "R4 right write 3FE sets left");
    lacc(0, 0, 1, 10'h100, 1, "R7 left write other address");
    lacc(0, 1, 0, 10'h3FD, 1, "R7 left read other address");
    lacc(0, 0, 1, NXT, 1, "R10 left write 3FE no effect");
    lacc(0, 1, 0, NXT, 0, "R8 left read busy keeps");
    lacc(0, 1, 0, NXT, 1, "R5 left read 3FE clears");
    lacc(0, 0, 1, TOP, 0, "R8 left write busy no set");
    racc(0, 0, 1, NXT, 0, "R8 right write busy no set");
    cyc(0, 0, 1, TOP, 1, 0, 1, 0, TOP, 1, "R9 right set vs clear");
    cyc(0, 1, 0, NXT, 1, 0, 0, 1, NXT, 1, "R9 left set vs clear");
    cyc(0, 1, 0, NXT, 1, 0, 1, 0, TOP, 1, "R3 R5 both clear");
    lacc(1, 1, 1, '0, 1, "R7 idle");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule